// File: doc/BRIEF.md
# Retention Mode Unlock Detector

This block sits on the device side of an asynchronous SRAM-style memory port. It watches the stream of completed accesses and picks out a fixed six-access unlock sequence. That sequence selects how much of the array keeps its contents while the part is powered down. Each completed access arrives as a one-cycle event that carries the direction, a 21-bit address and 16 bits of data. For a read, the data is the value the array returned. For a write, it is the value being written.

The sequence runs as follows. First, a read at the all-ones address. Next, two writes to that address that return the value just read. Then a write of zero to that address, and a write of a two-bit data key to that address. Last, a read whose upper two address bits form an address key. The block updates its retention mode register only when both keys name the same mode. Any access that does not fit the expected step abandons the sequence. The block also tells the array, for each write event, whether that write must be stored as an ordinary write.

The mode register drives the retention window. That window is an enable plus the highest retained address, and the window always starts at address zero.

Top module: `retain_unlock`

## Requirements
- R1: After reset, and again after any reset that arrives partway through a sequence, `modeReg` is 2'b11 (sleep). Reset also discards any partial sequence.
- R2: A full valid sequence sets `modeReg` to the data key in the clock cycle that follows the final read. The data key is taken from data bits [1:0] with 11 = sleep, 10 = quarter (4 Mbit), 01 = half (8 Mbit), 00 = full (16 Mbit). The sequence is: read at 1FFFFFh, write the read value to 1FFFFFh twice, write 0000h to 1FFFFFh, write the key to 1FFFFFh, then read the address key.
- R3: The retention window follows `modeReg`. In sleep, `retainEn` is 0 and `retainTop` is 0. Otherwise `retainEn` is 1 and `retainTop` is 03FFFFh for 10, 07FFFFh for 01 and 0FFFFFh for 00.
- R4: In the first or second write-back step, a write to any address other than 1FFFFFh abandons the sequence, and `commitWrite` is 1 for that write.
- R5: In the first or second write-back step, a write whose data differs from the captured read data abandons the sequence, and `commitWrite` is 1 for that write.
- R6: In the zero-write or key-write step, a write to any address other than 1FFFFFh abandons the sequence. A zero-write step with nonzero data also abandons it. In both cases `commitWrite` is 0 for that write.
- R7: `commitWrite` is 0 for every read, for every write taken in the zero-write or key-write step, and whenever `evValid` is low. It is 1 for every other valid write.
- R8: The final read leaves `modeReg` unchanged in two cases. The first is that its address bits [18:0] are not all ones. The second is that its address key names a different mode from the data key. The address key is read from A20:A19, with 11 = sleep, 01 = quarter, 10 = half, 00 = full.
- R9: In a write step, a read event abandons the sequence and is then judged as a fresh first step, so a read at 1FFFFFh restarts it. In the final step, a write event abandons the sequence and is treated as an ordinary write.
- R10: Data bits [15:2] of the key write have no effect on the mode that is selected.
- R11: A cycle with `evValid` low has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | A completed access is presented this cycle |
| evWrite | input | 1 | 1 = write access, 0 = read access |
| evAddr | input | 21 | Address of the access |
| evData | input | 16 | Read-return or write data |
| commitWrite | output | 1 | The current write event must be stored as an ordinary write |
| modeReg | output | 2 | Retention mode register (encoding in R2) |
| retainEn | output | 1 | Some part of the array is retained in power-down |
| retainTop | output | 21 | Highest retained address |

## Verification
Full sequences are run with each of the four keys. These runs show that the key decode and the window widths are distinct for every mode. Each abort point is then hit in turn: a wrong address, wrong write-back data, nonzero data in the zero-write step, a wrong key address, and a wrong access direction. Each abort run checks the `commitWrite` value at the failing access. The following access or final read then shows that the sequence really was abandoned and did not just stall. Further runs cover a key write with junk in its upper data bits, an invalid cycle inside a sequence, a restart partway through, and a reset partway through. These show that the state is neither disturbed by noise nor kept past reset.

// File: rtl/retain_unlock_pkg.sv
package retain_unlock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GOT_READ,
    ST_WB_ONE,
    ST_WB_TWO,
    ST_GOT_ZERO,
    ST_GOT_KEY
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capRead;
    logic capKey;
    logic applyMode;
  } seqStrobe_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic atTop;
    logic dataMatch;
    logic dataZero;
    logic keyAddrOk;
    logic keysAgree;
  } seqFlag_t;

  localparam int KEY_W = 2;
  localparam logic [KEY_W-1:0] MODE_SLEEP   = 2'b11;
  localparam logic [KEY_W-1:0] MODE_QUARTER = 2'b10;
  localparam logic [KEY_W-1:0] MODE_HALF    = 2'b01;
  localparam logic [KEY_W-1:0] MODE_FULL    = 2'b00;

endpackage

// File: rtl/retain_unlock_ctrl.sv
module retain_unlock_ctrl
  import retain_unlock_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evValid,
  input  logic       evWrite,
  input  seqFlag_t   flags,
  output seqStrobe_t stb,
  output logic       commitWrite
);

  seqState_t state, nxtState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  always_comb begin
    nxtState = state;
    stb      = '0;
    if (evValid) begin
      if (!evWrite) begin
        if (state == ST_GOT_KEY) begin
          stb.applyMode = flags.keyAddrOk && flags.keysAgree;
          nxtState      = ST_IDLE;
        end else if (flags.atTop) begin
          stb.capRead = 1'b1;
          nxtState    = ST_GOT_READ;
        end else begin
          nxtState = ST_IDLE;
        end
      end else begin
        unique case (state)
          ST_GOT_READ: nxtState = (flags.atTop && flags.dataMatch) ? ST_WB_ONE : ST_IDLE;
          ST_WB_ONE:   nxtState = (flags.atTop && flags.dataMatch) ? ST_WB_TWO : ST_IDLE;
          ST_WB_TWO:   nxtState = (flags.atTop && flags.dataZero) ? ST_GOT_ZERO : ST_IDLE;
          ST_GOT_ZERO: begin
            if (flags.atTop) begin
              stb.capKey = 1'b1;
              nxtState   = ST_GOT_KEY;
            end else begin
              nxtState = ST_IDLE;
            end
          end
          default:     nxtState = ST_IDLE;
        endcase
      end
    end
  end

  // key-phase writes are swallowed, all other writes reach the array
  assign commitWrite = evValid && evWrite &&
                       (state != ST_WB_TWO) && (state != ST_GOT_ZERO);

  AST_COMMIT_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    commitWrite |-> (evValid && evWrite)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)); // R2
  AST_APPLY_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    stb.applyMode |-> (evValid && !evWrite && flags.keyAddrOk)); // R8
  AST_IDLE_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !evValid |=> $stable(state)); // R11

endmodule

// File: rtl/retain_unlock_dp.sv
module retain_unlock_dp
  import retain_unlock_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic [DATA_W-1:0] evData,
  input  seqStrobe_t        stb,
  output seqFlag_t          flags,
  output logic [KEY_W-1:0]  modeReg,
  output logic              retainEn,
  output logic [ADDR_W-1:0] retainTop
);

  localparam int LOW_W = ADDR_W - KEY_W;     // bits that must be all ones in the key address
  localparam int BASE  = ADDR_W - 3;         // log2 of the smallest retained window
  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

  logic [DATA_W-1:0] capData;
  logic [KEY_W-1:0]  keyQ;
  logic [KEY_W-1:0]  modeQ;
  logic [KEY_W-1:0]  addrKey;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capData <= '0;
      keyQ    <= MODE_SLEEP;
      modeQ   <= MODE_SLEEP;
    end else begin
      if (stb.capRead)   capData <= evData;
      if (stb.capKey)    keyQ    <= evData[KEY_W-1:0];
      if (stb.applyMode) modeQ   <= keyQ;
    end
  end

  // address key: A[top] and A[top-1] swapped onto the data key encoding
  assign addrKey = {evAddr[ADDR_W-2], evAddr[ADDR_W-1]};

  always_comb begin
    flags.atTop     = (evAddr == ALL_ONES);
    flags.dataMatch = (evData == capData);
    flags.dataZero  = (evData == '0);
    flags.keyAddrOk = &evAddr[LOW_W-1:0];
    flags.keysAgree = (addrKey == keyQ);
  end

  always_comb begin
    retainEn  = 1'b1;
    retainTop = '0;
    unique case (modeQ)
      MODE_QUARTER: retainTop = ALL_ONES >> 3;
      MODE_HALF:    retainTop = ALL_ONES >> 2;
      MODE_FULL:    retainTop = ALL_ONES >> 1;
      default:      retainEn  = 1'b0;
    endcase
  end

  assign modeReg = modeQ;

  AST_MODE_ONLY_ON_APPLY: assert property (@(posedge clk) disable iff (!rstN)
    !stb.applyMode |=> $stable(modeQ)); // R8
  AST_WINDOW_FORM: assert property (@(posedge clk) disable iff (!rstN)
    retainEn |-> ((&retainTop[BASE-1:0]) && !retainTop[ADDR_W-1])); // R3
  AST_KEY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capKey |=> $stable(keyQ)); // R10

endmodule

// File: rtl/retain_unlock.sv
module retain_unlock
  import retain_unlock_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  input  logic              evWrite,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic [DATA_W-1:0] evData,
  output logic              commitWrite,
  output logic [1:0]        modeReg,
  output logic              retainEn,
  output logic [ADDR_W-1:0] retainTop
);

  seqStrobe_t stb;
  seqFlag_t   flags;

  retain_unlock_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .evValid     (evValid),
    .evWrite     (evWrite),
    .flags       (flags),
    .stb         (stb),
    .commitWrite (commitWrite)
  );

  retain_unlock_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .evAddr    (evAddr),
    .evData    (evData),
    .stb       (stb),
    .flags     (flags),
    .modeReg   (modeReg),
    .retainEn  (retainEn),
    .retainTop (retainTop)
  );

  AST_SLEEP_NOTHING_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_SLEEP) |-> (!retainEn && retainTop == '0)); // R3
  AST_NO_COMMIT_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !evWrite) |-> !commitWrite); // R7

endmodule

// File: tb/tb_retain_unlock.sv
module tb_retain_unlock;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evValid = 1'b0;
  logic        evWrite = 1'b0;
  logic [20:0] evAddr = '0;
  logic [15:0] evData = '0;
  logic        commitWrite;
  logic [1:0]  modeReg;
  logic        retainEn;
  logic [20:0] retainTop;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  retain_unlock dut (
    .clk (clk), .rstN (rstN), .evValid (evValid), .evWrite (evWrite),
    .evAddr (evAddr), .evData (evData), .commitWrite (commitWrite),
    .modeReg (modeReg), .retainEn (retainEn), .retainTop (retainTop)
  );

  typedef struct packed {
    logic        v;
    logic        w;
    logic [20:0] a;
    logic [15:0] d;
    logic        c;
    logic [1:0]  m;
    logic [3:0]  r;
  } vec_t;

  localparam logic [20:0] T = 21'h1FFFFF;

  localparam vec_t VEC [64] = '{
    // R2 quarter mode
    '{1,0,T,16'hABCD,0,3,2}, '{1,1,T,16'hABCD,1,3,7}, '{1,1,T,16'hABCD,1,3,7},
    '{1,1,T,16'h0000,0,3,7}, '{1,1,T,16'h0002,0,3,7}, '{1,0,21'h0FFFFF,16'h0,0,2,2},
    // R10 junk upper key bits, R11 invalid cycle inside, half mode
    '{1,0,T,16'h1234,0,2,2}, '{0,1,21'h000000,16'hDEAD,0,2,11}, '{1,1,T,16'h1234,1,2,11},
    '{1,1,T,16'h1234,1,2,2}, '{1,1,T,16'h0000,0,2,2}, '{1,1,T,16'hFF01,0,2,10},
    '{1,0,21'h17FFFF,16'h0,0,1,10},
    // full mode
    '{1,0,T,16'h00FF,0,1,2}, '{1,1,T,16'h00FF,1,1,2}, '{1,1,T,16'h00FF,1,1,2},
    '{1,1,T,16'h0000,0,1,2}, '{1,1,T,16'h0000,0,1,2}, '{1,0,21'h07FFFF,16'h0,0,0,3},
    // R8 key disagreement
    '{1,0,T,16'h4242,0,0,8}, '{1,1,T,16'h4242,1,0,8}, '{1,1,T,16'h4242,1,0,8},
    '{1,1,T,16'h0000,0,0,8}, '{1,1,T,16'h0002,0,0,8}, '{1,0,21'h17FFFF,16'h0,0,0,8},
    // back to sleep, R3 window off
    '{1,0,T,16'h0F0F,0,0,2}, '{1,1,T,16'h0F0F,1,0,2}, '{1,1,T,16'h0F0F,1,0,2},
    '{1,1,T,16'h0000,0,0,2}, '{1,1,T,16'h0003,0,0,2}, '{1,0,T,16'h0,0,3,3},
    // R4 wrong write-back address
    '{1,0,T,16'h5555,0,3,4}, '{1,1,21'h000100,16'h5555,1,3,4}, '{1,1,T,16'h5555,1,3,4},
    '{1,0,21'h07FFFF,16'h0,0,3,4},
    // R5 wrong write-back data
    '{1,0,T,16'h5555,0,3,5}, '{1,1,T,16'h5555,1,3,5}, '{1,1,T,16'h5556,1,3,5},
    '{1,1,T,16'h0000,1,3,5},
    // R6 wrong zero-write address
    '{1,0,T,16'h0007,0,3,6}, '{1,1,T,16'h0007,1,3,6}, '{1,1,T,16'h0007,1,3,6},
    '{1,1,21'h000010,16'h0000,0,3,6}, '{1,1,T,16'h0000,1,3,6},
    // R9 restart by read, full mode
    '{1,0,T,16'h1111,0,3,9}, '{1,1,T,16'h1111,1,3,9}, '{1,0,T,16'h2222,0,3,9},
    '{1,1,T,16'h2222,1,3,9}, '{1,1,T,16'h2222,1,3,9}, '{1,1,T,16'h0000,0,3,9},
    '{1,1,T,16'h0000,0,3,9}, '{1,0,21'h07FFFF,16'h0,0,0,9},
    // R8 key address low bits not all ones
    '{1,0,T,16'h3C3C,0,0,8}, '{1,1,T,16'h3C3C,1,0,8}, '{1,1,T,16'h3C3C,1,0,8},
    '{1,1,T,16'h0000,0,0,8}, '{1,1,T,16'h0001,0,0,8}, '{1,0,21'h17FFFE,16'h0,0,0,8},
    // R9 write in final step
    '{1,0,T,16'h0003,0,0,9}, '{1,1,T,16'h0003,1,0,9}, '{1,1,T,16'h0003,1,0,9},
    '{1,1,T,16'h0000,0,0,9}, '{1,1,T,16'h0003,0,0,9}, '{1,1,21'h000000,16'hAAAA,1,0,9}
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkWindow(input logic [1:0] m, input int req);
    logic        eEn;
    logic [20:0] eTop;
    case (m)
      2'b10:   begin eEn = 1; eTop = 21'h03FFFF; end
      2'b01:   begin eEn = 1; eTop = 21'h07FFFF; end
      2'b00:   begin eEn = 1; eTop = 21'h0FFFFF; end
      default: begin eEn = 0; eTop = 21'h0; end
    endcase
    check(modeReg === m, req, "modeReg", 32'(modeReg), 32'(m));
    check(retainEn === eEn && retainTop === eTop, 3, "window",
          {retainEn, 10'h0, retainTop}, {eEn, 10'h0, eTop});
  endtask

  task automatic send(input logic v, input logic w, input logic [20:0] a,
                      input logic [15:0] d, input logic c, input logic [1:0] m,
                      input int req);
    @(negedge clk);
    evValid = v; evWrite = w; evAddr = a; evData = d;
    #1;
    check(commitWrite === c, req, "commitWrite", 32'(commitWrite), 32'(c));
    @(posedge clk);
    #1;
    checkWindow(m, req);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    checkWindow(2'b11, 1);
    check(commitWrite === 1'b0, 7, "commit idle", 32'(commitWrite), 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < 64; i++)
      send(VEC[i].v, VEC[i].w, VEC[i].a, VEC[i].d, VEC[i].c, VEC[i].m, int'(VEC[i].r));

    // R6 wrong key-write address: no mode change
    send(1, 0, T, 16'h0001, 0, 0, 6);
    send(1, 1, T, 16'h0001, 1, 0, 6);
    send(1, 1, T, 16'h0001, 1, 0, 6);
    send(1, 1, T, 16'h0000, 0, 0, 6);
    send(1, 1, 21'h0000FF, 16'h0002, 0, 0, 6);
    send(1, 0, 21'h0FFFFF, 16'h0, 0, 0, 6);
    // R6 nonzero data in zero-write step
    send(1, 0, T, 16'h0001, 0, 0, 6);
    send(1, 1, T, 16'h0001, 1, 0, 6);
    send(1, 1, T, 16'h0001, 1, 0, 6);
    send(1, 1, T, 16'h0001, 0, 0, 6);
    send(1, 1, T, 16'h0002, 1, 0, 6);
    send(1, 0, 21'h0FFFFF, 16'h0, 0, 0, 6);
    // R1 reset partway through a sequence
    send(1, 0, T, 16'h0001, 0, 0, 1);
    send(1, 1, T, 16'h0001, 1, 0, 1);
    send(1, 1, T, 16'h0001, 1, 0, 1);
    send(1, 1, T, 16'h0000, 0, 0, 1);
    send(1, 1, T, 16'h0002, 0, 0, 1);
    @(negedge clk);
    evValid = 1'b0;
    rstN = 1'b0;
    @(posedge clk);
    #1;
    checkWindow(2'b11, 1);
    @(negedge clk);
    rstN = 1'b1;
    send(1, 0, 21'h0FFFFF, 16'h0, 0, 3, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule